// File: doc/BRIEF.md
# Timed Test Coprocessor

This block is a coprocessor for processor validation benches. It keeps sixteen 32-bit scratch registers that the core reads and writes with register-move requests and with single-word or multi-word load/store transfers. Its data-operation commands do not compute anything. They set up timed events instead: a busy-wait of a programmed length, an active-low fast or normal interrupt line that falls after a programmed delay, release of either line, and capture of a free-running cycle counter into a register.

Each request comes with a kind, a first-phase flag, the 32-bit instruction word and write data. The block answers in the same cycle with one of four response codes. A control state machine has three states:
- `ST_IDLE`: nothing pending.
- `ST_WAIT`: a busy-wait is counting down.
- `ST_BURST`: a long transfer is part-way through its data beats.

The transitions are:
- `ST_IDLE`→`ST_WAIT` on a busy-wait start with a nonzero count.
- `ST_WAIT`→`ST_IDLE` on the poll that finds the wait over.
- `ST_IDLE`→`ST_BURST` on the first long data beat.
- `ST_BURST`→`ST_IDLE` on the terminal beat or on a non-data transfer phase.

Top module: `timed_test_cop`

## Requirements
- R1: After reset all sixteen registers read zero, both interrupt lines are high, and the cycle counter is zero.
- R2: A move request (kind 0) with instruction bit 20 clear writes the write data into the register selected by bits 19:16. With bit 20 set, it returns that register on the read-data port in the same cycle. Both answer done (code 0).
- R3: A data operation (kind 1, first phase) with opcode 0 (instruction bits 23:20) starts a busy-wait of N cycles, where N is the register selected by bits 3:0. The start cycle T answers busy (code 1). A poll (kind 1, first flag clear) in cycle T+k answers busy while k < N and done once k >= N.
- R4: A busy-wait whose count is zero answers done in its start cycle.
- R5: Opcode 1, issued in cycle T with count N, drives the fast interrupt line low from cycle T+max(N,1). Opcode 2 does the same for the normal interrupt line.
- R6: Opcode 3 raises the fast line and opcode 4 raises the normal line in the next cycle. Each also cancels that line's pending timer.
- R7: Opcode 1 or 2 reissued while its timer is pending restarts the delay from the new command.
- R8: Opcode 5 writes the value the cycle counter holds in the request cycle into the register selected by bits 3:0. The counter starts at zero after reset and adds one at every clock.
- R9: Opcodes 6 to 15 and request kind 3 answer cannot-execute (code 2) and change no register and no line.
- R10: A transfer (kind 2) data beat selects its register by bits 15:12. With bit 20 set it loads the write data into that register; with bit 20 clear it returns the register on read data. A short transfer (bit 22 clear) answers done.
- R11: A long transfer (bit 22 set) answers increment (code 3) for its first four data beats and done on the fifth. A non-data phase (kind 2, first flag set) answers done and restarts the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is presented this cycle |
| req_kind_i | input | 2 | 0 move, 1 data operation, 2 transfer, 3 unsupported |
| req_first_i | input | 1 | Data operation: start (1) or poll (0). Transfer: non-data phase (1) or data beat (0) |
| instr_i | input | 32 | Instruction word carrying the register, opcode and option fields |
| wdata_i | input | 32 | Data from the core |
| resp_o | output | 2 | 0 done, 1 busy, 2 cannot-execute, 3 increment |
| rdata_o | output | 32 | Data to the core |
| fiq_n_o | output | 1 | Fast interrupt line, active low |
| irq_n_o | output | 1 | Normal interrupt line, active low |

## Verification
A wrong remaining count shows at the next poll: the answer turns to done one cycle too early or stays busy one cycle too long. This is caught because every poll cycle is compared. A mis-set timer shows as an interrupt edge displaced by one or more cycles, and the bench samples the lines in each cycle around the expected edge. A beat counter that is off by one shows as a done or increment answer on the wrong beat. A captured timestamp is compared with a counter the bench keeps itself, so a single-cycle skew in capture is exposed.

// File: rtl/tcop_pkg.sv
package tcop_pkg;
    typedef enum logic [1:0] {
        RSP_DONE = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_CANT = 2'd2,
        RSP_INC  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        K_MOVE = 2'd0,
        K_OP   = 2'd1,
        K_XFER = 2'd2,
        K_NONE = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_BURST = 2'd2
    } state_e;
endpackage

// File: rtl/tcop_regfile.sv
module tcop_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdat,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdat_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdat_b
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdat;
        end
    end

    assign rdat_a = mem[raddr_a];
    assign rdat_b = mem[raddr_b];
endmodule

// File: rtl/tcop_irq_timer.sv
module tcop_irq_timer #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] count,
    input  logic          release_i,
    output logic          line_n
);
    logic          armed;
    logic [DW-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_n <= 1'b1;
            armed  <= 1'b0;
            left   <= '0;
        end else if (load) begin
            if (count <= DW'(1)) begin
                line_n <= 1'b0;
                armed  <= 1'b0;
            end else begin
                armed <= 1'b1;
                left  <= count - DW'(2);
            end
        end else if (release_i) begin
            line_n <= 1'b1;
            armed  <= 1'b0;
        end else if (armed) begin
            if (left == '0) begin
                line_n <= 1'b0;
                armed  <= 1'b0;
            end else begin
                left <= left - DW'(1);
            end
        end
    end

    // R6: a release leaves the line high in the next cycle
    a_r6_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !load) |=> line_n);

    // R5: counts of zero or one assert the line at the next edge
    a_r5_short_count_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load && count <= DW'(1)) |=> !line_n);
endmodule

// File: rtl/timed_test_cop.sv
module timed_test_cop #(
    parameter int DW        = 32,
    parameter int NREG      = 16,
    parameter int BEAT_TERM = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic [1:0]    req_kind_i,
    input  logic          req_first_i,
    input  logic [31:0]   instr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [1:0]    resp_o,
    output logic [DW-1:0] rdata_o,
    output logic          fiq_n_o,
    output logic          irq_n_o
);
    import tcop_pkg::*;

    localparam int AW = $clog2(NREG);
    localparam int BW = $clog2(BEAT_TERM + 1);

    state_e st, nxt;

    logic [AW-1:0] mv_idx, xf_idx, crm_idx, raddr_a, waddr;
    logic [3:0]    opc;
    logic [DW-1:0] rd_a, operand, wdat, cyc, remain;
    logic [BW-1:0] beats;
    logic          we, wait_load, beat_clr, beat_inc;
    logic [1:0]    ld, rel;
    rsp_e          rsp;

    assign mv_idx  = instr_i[16 +: AW];
    assign xf_idx  = instr_i[12 +: AW];
    assign crm_idx = instr_i[0 +: AW];
    assign opc     = instr_i[23:20];
    assign raddr_a = (req_kind_i == K_XFER) ? xf_idx : mv_idx;

    tcop_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we(we), .waddr(waddr), .wdat(wdat),
        .raddr_a(raddr_a), .rdat_a(rd_a),
        .raddr_b(crm_idx), .rdat_b(operand)
    );

    // one timer per interrupt line: index 0 fast, index 1 normal
    logic [1:0] line_n;
    for (genvar g = 0; g < 2; g++) begin : g_tmr
        tcop_irq_timer #(.DW(DW)) u_tmr (
            .clk(clk), .rst_n(rst_n),
            .load(ld[g]), .count(operand), .release_i(rel[g]),
            .line_n(line_n[g])
        );
    end
    assign fiq_n_o = line_n[0];
    assign irq_n_o = line_n[1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // counters that run beside the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc    <= '0;
            remain <= '0;
            beats  <= '0;
        end else begin
            cyc <= cyc + DW'(1);
            if (wait_load)          remain <= operand - DW'(1);
            else if (remain != '0)  remain <= remain - DW'(1);
            if (beat_clr)           beats <= '0;
            else if (beat_inc)      beats <= beats + BW'(1);
        end
    end

    // outputs and next state
    always_comb begin
        nxt = st; rsp = RSP_DONE; rdata_o = '0;
        we = 1'b0; waddr = mv_idx; wdat = wdata_i;
        ld = 2'b00; rel = 2'b00;
        wait_load = 1'b0; beat_clr = 1'b0; beat_inc = 1'b0;
        if (req_valid_i) begin
            unique case (req_kind_i)
                K_MOVE: begin
                    if (instr_i[20]) rdata_o = rd_a;
                    else             we = 1'b1;
                end
                K_OP: begin
                    if (req_first_i) begin
                        unique case (opc)
                            4'd0: begin
                                if (operand == '0) begin
                                    nxt = ST_IDLE;
                                end else begin
                                    rsp = RSP_BUSY; wait_load = 1'b1; nxt = ST_WAIT;
                                end
                            end
                            4'd1: ld[0] = 1'b1;
                            4'd2: ld[1] = 1'b1;
                            4'd3: rel[0] = 1'b1;
                            4'd4: rel[1] = 1'b1;
                            4'd5: begin
                                we = 1'b1; waddr = crm_idx; wdat = cyc;
                            end
                            default: rsp = RSP_CANT;
                        endcase
                    end else if (st == ST_WAIT) begin
                        if (remain == '0) nxt = ST_IDLE;
                        else              rsp = RSP_BUSY;
                    end
                end
                K_XFER: begin
                    if (req_first_i) begin
                        beat_clr = 1'b1;
                        if (st == ST_BURST) nxt = ST_IDLE;
                    end else begin
                        if (instr_i[20]) begin
                            we = 1'b1; waddr = xf_idx;
                        end else begin
                            rdata_o = rd_a;
                        end
                        if (instr_i[22]) begin
                            if (beats == BW'(BEAT_TERM)) begin
                                beat_clr = 1'b1; nxt = ST_IDLE;
                            end else begin
                                rsp = RSP_INC; beat_inc = 1'b1; nxt = ST_BURST;
                            end
                        end
                    end
                end
                default: rsp = RSP_CANT;
            endcase
        end
        resp_o = rsp;
    end

    // R11: the beat counter never passes its terminal count
    a_r11_beats_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        beats <= BW'(BEAT_TERM));

    // R3: a busy answer only comes from a wait being started or in progress
    a_r3_busy_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_o == RSP_BUSY) |-> (st == ST_WAIT || wait_load));

    // R4: a zero operand on a busy-wait start completes in that cycle
    a_r4_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == K_OP && req_first_i && opc == 4'd0 && operand == '0)
        |-> resp_o == RSP_DONE);

    // R3: a started wait moves the machine into ST_WAIT
    a_r3_enter_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_kind_i == K_OP && req_first_i && opc == 4'd0 && operand != '0)
        |=> st == ST_WAIT);
endmodule

// File: tb/tb_timed_test_cop.sv
`timescale 1ns/1ps
module tb_timed_test_cop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic        req_first_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [1:0]  resp_o;
    logic [31:0] rdata_o;
    logic        fiq_n_o, irq_n_o;

    int nchk = 0, nfail = 0;
    logic [31:0] bcnt;
    logic [1:0]  r_resp;
    logic [31:0] r_data;

    localparam logic [1:0] DONE = 2'd0, BUSY = 2'd1, CANT = 2'd2, INC = 2'd3;

    timed_test_cop dut (.*);

    always #4 clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) bcnt <= '0; else bcnt <= bcnt + 32'd1;

    // kind(2) first(1) instr(32) wdata(32) resp(2) rdata(32)
    localparam int NV = 8;
    localparam logic [100:0] VEC [NV] = '{
        {2'd0, 1'b0, 32'h0001_0000, 32'hA5A5_0001, DONE, 32'h0},
        {2'd0, 1'b0, 32'h0003_0000, 32'h0000_0004, DONE, 32'h0},
        {2'd0, 1'b0, 32'h0005_0000, 32'h0000_0003, DONE, 32'h0},
        {2'd0, 1'b0, 32'h000A_0000, 32'hDEAD_BEEF, DONE, 32'h0},
        {2'd0, 1'b0, 32'h0011_0000, 32'h0,         DONE, 32'hA5A5_0001},
        {2'd0, 1'b0, 32'h001A_0000, 32'h0,         DONE, 32'hDEAD_BEEF},
        {2'd0, 1'b0, 32'h0013_0000, 32'h0,         DONE, 32'h0000_0004},
        {2'd0, 1'b0, 32'h0017_0000, 32'h0,         DONE, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts at a falling edge, samples the same-cycle answer, ends at the next falling edge
    task automatic issue(input logic [1:0] k, input logic f, input logic [31:0] ins, input logic [31:0] wd);
        req_valid_i = 1'b1; req_kind_i = k; req_first_i = f; instr_i = ins; wdata_i = wd;
        #1;
        r_resp = resp_o; r_data = rdata_o;
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    function automatic logic [31:0] mk_op(input int op, input int crm);
        return (32'(op) << 20) | 32'(crm);
    endfunction

    function automatic logic [31:0] mk_rd(input int idx);
        return 32'h0010_0000 | (32'(idx) << 16);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail);
        $finish;
    end

    initial begin
        logic [31:0] cval;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 fiq_n", 32'(fiq_n_o), 32'd1);
        check("R1 irq_n", 32'(irq_n_o), 32'd1);
        issue(2'd0, 1'b0, mk_rd(0), '0);
        check("R1 reg0", r_data, 32'h0);

        // R2 table of moves
        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][100:99], VEC[i][98], VEC[i][97:66], VEC[i][65:34]);
            check("R2 resp", 32'(r_resp), 32'(VEC[i][33:32]));
            if (VEC[i][86]) check("R2 rdata", r_data, VEC[i][31:0]);
        end

        // R3 busy-wait of 4 (reg3)
        issue(2'd1, 1'b1, mk_op(0, 3), '0);
        check("R3 start busy", 32'(r_resp), 32'(BUSY));
        for (int k = 1; k <= 4; k++) begin
            issue(2'd1, 1'b0, 32'h0, '0);
            check("R3 poll", 32'(r_resp), (k < 4) ? 32'(BUSY) : 32'(DONE));
        end

        // R4 zero count (reg7 = 0)
        issue(2'd1, 1'b1, mk_op(0, 7), '0);
        check("R4 zero done", 32'(r_resp), 32'(DONE));

        // R5 fast line after 3 cycles (reg5 = 3)
        issue(2'd1, 1'b1, mk_op(1, 5), '0);
        check("R5 T+1 high", 32'(fiq_n_o), 32'd1);
        idle(1); check("R5 T+2 high", 32'(fiq_n_o), 32'd1);
        idle(1); check("R5 T+3 low", 32'(fiq_n_o), 32'd0);

        // R6 release fast line
        issue(2'd1, 1'b1, mk_op(3, 0), '0);
        check("R6 fiq released", 32'(fiq_n_o), 32'd1);

        // R5 normal line with zero count (reg7 = 0): low next cycle
        issue(2'd1, 1'b1, mk_op(2, 7), '0);
        check("R5 irq immediate", 32'(irq_n_o), 32'd0);
        issue(2'd1, 1'b1, mk_op(4, 0), '0);
        check("R6 irq released", 32'(irq_n_o), 32'd1);

        // R7 restart: second command at T+1 moves the edge to T+4
        issue(2'd1, 1'b1, mk_op(1, 5), '0);
        issue(2'd1, 1'b1, mk_op(1, 5), '0);
        check("R7 T+2 high", 32'(fiq_n_o), 32'd1);
        idle(1); check("R7 T+3 high", 32'(fiq_n_o), 32'd1);
        idle(1); check("R7 T+4 low", 32'(fiq_n_o), 32'd0);
        issue(2'd1, 1'b1, mk_op(3, 0), '0);

        // R6 cancel: pending timer released before expiry never fires
        issue(2'd1, 1'b1, mk_op(1, 5), '0);
        issue(2'd1, 1'b1, mk_op(3, 0), '0);
        idle(4);
        check("R6 cancel holds high", 32'(fiq_n_o), 32'd1);

        // R8 capture cycle counter into reg12
        cval = bcnt;
        issue(2'd1, 1'b1, mk_op(5, 12), '0);
        check("R8 resp", 32'(r_resp), 32'(DONE));
        issue(2'd0, 1'b0, mk_rd(12), '0);
        check("R8 timestamp", r_data, cval);

        // R9 unknown opcode and kind 3
        issue(2'd1, 1'b1, mk_op(7, 5), '0);
        check("R9 op7 cant", 32'(r_resp), 32'(CANT));
        issue(2'd3, 1'b0, 32'h0005_0000, 32'h1234_5678);
        check("R9 kind3 cant", 32'(r_resp), 32'(CANT));
        check("R9 fiq untouched", 32'(fiq_n_o), 32'd1);
        issue(2'd0, 1'b0, mk_rd(5), '0);
        check("R9 reg5 kept", r_data, 32'd3);

        // R10 short load then store on reg6
        issue(2'd2, 1'b0, 32'h0010_6000, 32'hCAFE_0006);
        check("R10 load done", 32'(r_resp), 32'(DONE));
        issue(2'd2, 1'b0, 32'h0000_6000, '0);
        check("R10 store data", r_data, 32'hCAFE_0006);

        // R11 long load: four increments then done
        issue(2'd2, 1'b1, 32'h0050_6000, '0);
        check("R11 nondata done", 32'(r_resp), 32'(DONE));
        for (int b = 0; b < 5; b++) begin
            issue(2'd2, 1'b0, 32'h0050_6000, 32'h100 + 32'(b));
            check("R11 beat", 32'(r_resp), (b < 4) ? 32'(INC) : 32'(DONE));
        end
        issue(2'd0, 1'b0, mk_rd(6), '0);
        check("R11 last beat stored", r_data, 32'h104);

        // R11 non-data phase mid-burst restarts the count
        issue(2'd2, 1'b0, 32'h0050_6000, 32'h1);
        issue(2'd2, 1'b0, 32'h0050_6000, 32'h2);
        issue(2'd2, 1'b1, 32'h0050_6000, '0);
        for (int b = 0; b < 5; b++) begin
            issue(2'd2, 1'b0, 32'h0050_6000, 32'h200);
            check("R11 restart beat", 32'(r_resp), (b < 4) ? 32'(INC) : 32'(DONE));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule